// File: doc/BRIEF.md
# Multi-Channel Prescaled Pulse-Width Modulator

This block drives several independent pulse-width-modulated outputs from one module clock. Software programs each channel through a single 32-bit word on a plain word-addressed write/read bus. The word carries an enable flag, a duty count and a clock divider. A channel's divider turns the module clock into a slower tick. That tick advances an 8-bit counter, so one output period always spans 256 ticks. The output is high while the counter is below the duty count.

Duty and divider updates made while a channel runs are held back until the running period ends, so every period on the pin is whole. Switching a channel on or off acts at once. A disabled channel sits low with its counters cleared, so re-enabling it starts a fresh period. The channel count is a parameter, with a single-channel build as a supported case.

Top module: `pwm_bank`

## Requirements
- R1: Control word layout: bit 31 is the enable, bits 24:16 are the 9-bit duty count (values 0..256), and bits 12:0 are the divider field. Read-back returns the last written word ANDed with 0x81FF1FFF, so every other bit reads zero.
- R2: Channel n sits at byte offset n*16. A read from an offset whose low nibble is nonzero, or whose channel index is at or above the channel count, returns zero. A write to such an offset changes no register and no output.
- R3: Writing a word with bit 31 clear forces the channel output low from the cycle after the write. The counters are held at zero, so a later enable starts at the beginning of a period.
- R4: With divider field s and duty d, one period lasts 256*(s+1) clock cycles. The output is high for min(d,256)*(s+1) of them, taken from the start of the period.
- R5: A duty of 0 keeps the output permanently low. A duty of 256 keeps it permanently high.
- R6: Enabling a disabled channel takes effect in the cycle after the write edge. That cycle is the first of a period, so the output is high in it whenever the duty is nonzero.
- R7: Duty and divider changes written to a running channel take effect only at the next period boundary. The current period completes with the old values.
- R8: Channels run independently. Programming one channel does not alter another channel's output.
- R9: A synchronous active-high reset clears every control word and drives all outputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst | input | 1 | Synchronous reset, active high |
| busWrEn | input | 1 | Write strobe, sampled on the rising clock edge |
| busAddr | input | ADDR_W | Byte address for reads and writes |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data, combinational from busAddr |
| pwmOut | output | NUM_CH | One modulated output per channel |

## Verification
A write lands on the clock edge that samples it. The output reflects the new enable in the very next cycle, because the comparator is combinational on registered state. Read data is combinational, so a read-back is valid one edge after the write. Each period-based result falls due exactly 256*(s+1) cycles after the start of a period. The bench samples at falling edges, counting from the first falling edge after the write edge as period index 0. It therefore checks high-time totals, the last sample of a period, and the first sample of the next period at fixed indices. For deferred updates the bench writes at a known index, then counts the rest of the old period and the whole new period separately.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;
  localparam int DATA_W    = 32;
  localparam int DUTY_W    = 9;
  localparam int SCALE_W   = 13;
  localparam int CNT_W     = 8;
  localparam int EN_BIT    = 31;
  localparam int DUTY_LSB  = 16;
  localparam int SCALE_LSB = 0;
  localparam int STRIDE_SH = 4;
  localparam logic [DATA_W-1:0] REG_MASK = 32'h81FF_1FFF;

  // Per-channel settings handed from control to datapath
  typedef struct packed {
    logic               en;
    logic [DUTY_W-1:0]  duty;
    logic [SCALE_W-1:0] scale;
  } chanCfg_t;
endpackage

// File: rtl/pwm_bank_ctrl.sv
module pwm_bank_ctrl
  import pwm_bank_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      busWrEn,
  input  logic [ADDR_W-1:0]         busAddr,
  input  logic [DATA_W-1:0]         busWrData,
  output logic [DATA_W-1:0]         busRdData,
  output chanCfg_t [NUM_CH-1:0]     chanCfg
);

  logic [DATA_W-1:0] regFile [NUM_CH];

  for (genvar i = 0; i < NUM_CH; i++) begin : g_reg
    localparam logic [ADDR_W-1:0] CH_ADDR = ADDR_W'(i << STRIDE_SH);
    logic wrHit;
    assign wrHit = busWrEn && (busAddr == CH_ADDR);

    always_ff @(posedge clk) begin
      if (rst) begin
        regFile[i] <= '0;
      end else if (wrHit) begin
        regFile[i] <= busWrData & REG_MASK;
      end
    end

    assign chanCfg[i].en    = regFile[i][EN_BIT];
    assign chanCfg[i].duty  = regFile[i][DUTY_LSB +: DUTY_W];
    assign chanCfg[i].scale = regFile[i][SCALE_LSB +: SCALE_W];
  end

  always_comb begin
    busRdData = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (busAddr == ADDR_W'(i << STRIDE_SH)) begin
        busRdData = busRdData | regFile[i];
      end
    end
  end

endmodule

// File: rtl/pwm_bank_chan.sv
module pwm_bank_chan
  import pwm_bank_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  chanCfg_t cfg,
  output logic     pwmOut
);

  logic               running;
  logic [SCALE_W-1:0] preCnt;
  logic [CNT_W-1:0]   perCnt;
  logic [DUTY_W-1:0]  actDuty;
  logic [SCALE_W-1:0] actScale;
  logic [DUTY_W-1:0]  effDuty;
  logic [SCALE_W-1:0] effScale;
  logic               tick;
  logic               wrap;

  // In the first enabled cycle the shadow is not yet loaded; use the live word
  assign effDuty  = running ? actDuty  : cfg.duty;
  assign effScale = running ? actScale : cfg.scale;
  assign tick     = (preCnt == effScale);
  assign wrap     = tick && (perCnt == {CNT_W{1'b1}});

  always_ff @(posedge clk) begin
    if (rst || !cfg.en) begin
      running  <= 1'b0;
      preCnt   <= '0;
      perCnt   <= '0;
      actDuty  <= '0;
      actScale <= '0;
    end else begin
      running <= 1'b1;
      if (!running || wrap) begin
        actDuty  <= cfg.duty;
        actScale <= cfg.scale;
      end
      if (tick) begin
        preCnt <= '0;
        perCnt <= perCnt + CNT_W'(1);
      end else begin
        preCnt <= preCnt + SCALE_W'(1);
      end
    end
  end

  assign pwmOut = cfg.en && ({1'b0, perCnt} < effDuty);

endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
  import pwm_bank_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWrData,
  output logic [31:0]       busRdData,
  output logic [NUM_CH-1:0] pwmOut
);

  chanCfg_t [NUM_CH-1:0] chanCfg;
  logic [NUM_CH-1:0]     chanEn;

  pwm_bank_ctrl #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .busWrEn   (busWrEn),
    .busAddr   (busAddr),
    .busWrData (busWrData),
    .busRdData (busRdData),
    .chanCfg   (chanCfg)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
    assign chanEn[i] = chanCfg[i].en;
    pwm_bank_chan u_chan (
      .clk    (clk),
      .rst    (rst),
      .cfg    (chanCfg[i]),
      .pwmOut (pwmOut[i])
    );
  end

endmodule

// File: rtl/pwm_bank_chk.sv
module pwm_bank_chk
  import pwm_bank_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              busWrEn,
  input logic [ADDR_W-1:0] busAddr,
  input logic [31:0]       busWrData,
  input logic [31:0]       busRdData,
  input logic [NUM_CH-1:0] pwmOut,
  input logic [NUM_CH-1:0] chanEn
);

  assert_reserved_zero_R1: assert property (@(posedge clk) disable iff (rst)
    (busRdData & ~REG_MASK) == 32'd0);

  assert_unmapped_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (busAddr[3:0] != 4'd0) |-> (busRdData == 32'd0));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic wrThis;
    assign wrThis = busWrEn && (busAddr == ADDR_W'(c << STRIDE_SH));

    assert_off_low_R3: assert property (@(posedge clk) disable iff (rst)
      (wrThis && !busWrData[EN_BIT]) |=> !pwmOut[c]);

    assert_zero_duty_R5: assert property (@(posedge clk) disable iff (rst)
      (wrThis && !chanEn[c] && busWrData[EN_BIT] && busWrData[24:16] == 9'd0)
      |=> !pwmOut[c]);

    assert_full_duty_R5: assert property (@(posedge clk) disable iff (rst)
      (wrThis && !chanEn[c] && busWrData[EN_BIT] && busWrData[24:16] == 9'd256)
      |=> pwmOut[c]);

    assert_start_high_R6: assert property (@(posedge clk) disable iff (rst)
      (wrThis && !chanEn[c] && busWrData[EN_BIT] && busWrData[24:16] != 9'd0)
      |=> pwmOut[c]);
  end

endmodule

bind pwm_bank pwm_bank_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/pwm_bank_tb.sv
module pwm_bank_tb;
  localparam int NUM_CH = 4;
  localparam int ADDR_W = 8;
  localparam int NVEC   = 8;

  // {duty[8:0], divider[12:0]}
  localparam logic [21:0] VEC [NVEC] = '{
    {9'd0,   13'd0}, {9'd1,   13'd0}, {9'd128, 13'd0}, {9'd255, 13'd0},
    {9'd256, 13'd0}, {9'd64,  13'd2}, {9'd200, 13'd1}, {9'd3,   13'd5}
  };

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              busWrEn = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic [31:0]       busWrData = '0;
  logic [31:0]       busRdData;
  logic [NUM_CH-1:0] pwmOut;

  int nChecks = 0;
  int nFail   = 0;

  always #2 clk = ~clk;

  pwm_bank #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rst(rst), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .pwmOut(pwmOut)
  );

  function automatic logic [31:0] mkWord(logic en, logic [8:0] duty, logic [12:0] sc);
    return {en, 6'd0, duty, 3'd0, sc};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the falling edge after the write edge
  task automatic wr(logic [ADDR_W-1:0] a, logic [31:0] d);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic rd(logic [ADDR_W-1:0] a, output logic [31:0] d);
    busAddr = a;
    #1;
    d = busRdData;
  endtask

  // Counts high samples of channel ch over n falling edges; reports the last one
  task automatic countHigh(int ch, int n, output int hi, output logic last);
    hi = 0; last = 1'b0;
    for (int i = 0; i < n; i++) begin
      if (pwmOut[ch]) hi++;
      last = pwmOut[ch];
      @(negedge clk);
    end
  endtask

  task automatic finish();
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired");
    finish();
  end

  initial begin
    logic [31:0] d;
    int hi, hi2;
    logic last;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R9: reset state
    check("R9 outputs after reset", 32'(pwmOut), 32'd0);
    for (int c = 0; c < NUM_CH; c++) begin
      rd(ADDR_W'(c * 16), d);
      check("R9 register after reset", d, 32'd0);
    end
    @(negedge clk);

    // Vector loop on channel 0: R4, R5, R6, R1
    for (int v = 0; v < NVEC; v++) begin
      logic [8:0]  dty;
      logic [12:0] sc;
      int per, expHi;
      dty = VEC[v][21:13];
      sc  = VEC[v][12:0];
      per = 256 * (int'(sc) + 1);
      expHi = int'(dty) * (int'(sc) + 1);
      wr(8'h00, 32'd0);
      wr(8'h00, mkWord(1'b1, dty, sc));
      rd(8'h00, d);
      check("R1 readback of vector word", d, mkWord(1'b1, dty, sc));
      check("R6 first sample after enable", 32'(pwmOut[0]), 32'(dty != 0));
      countHigh(0, per, hi, last);
      check("R4 high cycles in one period", 32'(hi), 32'(expHi));
      check("R5 R4 last sample of period", 32'(last), 32'(dty == 9'd256));
      check("R4 first sample of next period", 32'(pwmOut[0]), 32'(dty != 0));
    end

    // R3: disable forces low, holds low, and re-enable restarts the period
    wr(8'h00, 32'd0);
    check("R3 output low after disable", 32'(pwmOut[0]), 32'd0);
    rd(8'h00, d);
    check("R3 register cleared", d, 32'd0);
    countHigh(0, 300, hi, last);
    check("R3 no highs while disabled", 32'(hi), 32'd0);
    wr(8'h00, mkWord(1'b1, 9'd100, 13'd0));
    countHigh(0, 51, hi, last);
    // R7: rewrite duty and divider mid-period; sample 51 is now due
    wr(8'h00, mkWord(1'b1, 9'd200, 13'd1));
    countHigh(0, 205, hi, last);
    check("R7 old duty holds for rest of period", 32'(hi), 32'd49);
    countHigh(0, 512, hi, last);
    check("R7 new duty and divider after boundary", 32'(hi), 32'd400);
    wr(8'h00, 32'd0);

    // R1: reserved bits masked
    wr(8'h10, 32'hFFFF_FFFF);
    rd(8'h10, d);
    check("R1 reserved bits read zero", d, 32'h81FF_1FFF);
    wr(8'h10, 32'd0);

    // R2: offsets
    wr(8'h30, mkWord(1'b0, 9'd7, 13'd9));
    rd(8'h30, d);
    check("R2 channel 3 at offset 0x30", d, mkWord(1'b0, 9'd7, 13'd9));
    wr(8'h14, 32'h8000_0001);
    wr(8'h40, 32'h80FF_0000);
    rd(8'h14, d);
    check("R2 misaligned offset reads zero", d, 32'd0);
    rd(8'h40, d);
    check("R2 channel beyond count reads zero", d, 32'd0);
    rd(8'h10, d);
    check("R2 ignored write leaves channel 1", d, 32'd0);
    rd(8'h00, d);
    check("R2 ignored write leaves channel 0", d, 32'd0);
    check("R2 ignored writes leave outputs low", 32'(pwmOut), 32'd0);
    wr(8'h30, 32'd0);

    // R8: independent channels
    wr(8'h10, mkWord(1'b1, 9'd10, 13'd0));
    wr(8'h20, mkWord(1'b1, 9'd200, 13'd0));
    hi = 0; hi2 = 0;
    for (int i = 0; i < 256; i++) begin
      if (pwmOut[1]) hi++;
      if (pwmOut[2]) hi2++;
      if (pwmOut[0] || pwmOut[3]) hi = hi + 1000;
      @(negedge clk);
    end
    check("R8 channel 1 duty", 32'(hi), 32'd10);
    check("R8 channel 2 duty", 32'(hi2), 32'd200);

    // R9: mid-run reset
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R9 outputs cleared by reset", 32'(pwmOut), 32'd0);
    rd(8'h20, d);
    check("R9 register cleared by reset", d, 32'd0);

    finish();
  end

endmodule